// File: doc/BRIEF.md
# SPI Host Length-Counted Transfer Engine

This block is the host side of an SPI link with a 32-bit data port and 8-bit characters. Software-side logic sets a byte count between 1 and 255, fills transmit words through a two-stage path (a holding register in front of a shift word), and pulses `start`. The engine drops the select line, produces a mode 0 serial clock from the system clock, and sends the bytes of each word lowest byte first, each byte MSB first. It collects the bytes coming back into 32-bit words.

A receive-complete pulse marks every fourth byte. It also marks the last byte of a transfer whose length is not a multiple of four. A data-register-empty level asks for the next word. A sticky transmit-complete flag reports that the select line has been released and that no transmit data is left. Once enough words have been written to cover the programmed length, further writes are refused until transmit-complete has been set. If the next transmit word is late, the serial clock pauses with the select line held low.

Top module: `spi_len_host`

## Requirements
- R1: After reset, `ss_n`=1, `sck`=0, `mosi`=0, `dre`=1, `txc`=0, `rxc`=0 and `rd_data`=0.
- R2: `sck` is 0 and does not toggle while `ss_n` is 1. After `ss_n` falls, `sck` stays low for at least one half period before its first rise. Every high phase of `sck` lasts `cfg_half` system clocks, and `cfg_half`=0 is treated as 1, so the SCK period is an even divide of at least 2.
- R3: Byte k of a transfer is bits [8*(k%4)+7 : 8*(k%4)] of transmit word k/4, so byte 0 is bits [7:0]. Each byte is sent MSB first. `mosi` changes only while `sck` is low and holds its value across each rising edge.
- R4: With `cfg_len_en`=1, a transfer carries exactly `cfg_len` bytes (8 SCK rises each). With `cfg_len_en`=0, a transfer carries 4 bytes.
- R5: A `start` with `cfg_len_en`=1 and `cfg_len`=0 is ignored: `ss_n` stays 1, no SCK edge occurs and `txc` keeps its value.
- R6: The byte received at position k lands in bits [8*(k%4)+7 : 8*(k%4)] of `rd_data`. `rxc` pulses for one cycle after every fourth byte, and after the final byte when the length is not a multiple of 4. Unfilled upper bytes of that last word are 0.
- R7: `dre` is 1 while the holding register is empty. A write with `dre`=1 is captured and drops `dre` the next cycle. A write with `dre`=0 is discarded.
- R8: Once ceil(length/4) words have been accepted for the current length, further writes are discarded, and `dre` stays 1, until `txc` has been set.
- R9: `txc` rises in the cycle `ss_n` is released after the last byte, with the holding register empty. It stays 1 until the next accepted `start`, which clears it.
- R10: Length, length enable and divider are captured at the accepted `start`. Changing them during a transfer has no effect on that transfer.
- R11: If no transmit word is ready when a byte is due, `sck` stays low with `ss_n` held at 0 until a word is written. The transfer then completes with the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | 8 | SCK half period in system clocks (0 acts as 1) |
| cfg_len | input | 8 | Byte count of a transfer |
| cfg_len_en | input | 1 | 1: use `cfg_len`; 0: fixed 4-byte transfer |
| start | input | 1 | Begin a transfer when idle |
| wr_en | input | 1 | Write strobe for a transmit word |
| wr_data | input | 32 | Transmit word |
| dre | output | 1 | Holding register empty |
| rd_data | output | 32 | Last completed receive word |
| rxc | output | 1 | One-cycle receive-complete pulse |
| txc | output | 1 | Sticky transmit-complete flag |
| sck | output | 1 | Serial clock, idle low |
| ss_n | output | 1 | Active-low target select |
| mosi | output | 1 | Serial data to target |
| miso | input | 1 | Serial data from target |

## Verification
The assertions check on every cycle that `sck` stays inside the select window, that `rxc` is a single-cycle pulse inside a frame, and that `txc` rises only with the select line released and the holding register empty. They also check that a starting frame clears `txc` and that an accepted write empties `dre`. Byte ordering, packing of partial final words, the exact byte count, the divider width, captured configuration, refused writes and the stall on a late word all depend on whole-transfer data. Only the bench's scenarios, run against a target model, can show them.

// File: rtl/spi_len_pkg.sv
package spi_len_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_BYTES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  lane_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_WAIT,
        ST_TRAIL
    } state_e;

    // Place one byte into a word at a lane position.
    function automatic word_t put_lane(word_t w, lane_t i, byte_t b);
        word_t r;
        r = w;
        r[i*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction

endpackage

// File: rtl/spi_len_clkgen.sv
module spi_len_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = (half == '0) ? DIV_W'(1) : half;
        tick = en && (cnt == lim - DIV_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_len_shifter.sv
module spi_len_shifter
    import spi_len_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t load_byte,
    input  logic  rise,
    input  logic  fall,
    input  logic  miso,
    output logic  mosi,
    output byte_t rx_byte,
    output logic  bit_last
);
    localparam int BC_W = $clog2(BYTE_W);

    byte_t         tx_sr;
    byte_t         rx_sr;
    logic [BC_W-1:0] bit_cnt;

    assign mosi     = tx_sr[BYTE_W-1];
    assign rx_byte  = rx_sr;
    assign bit_last = (bit_cnt == BC_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else begin
            if (rise) begin
                rx_sr <= {rx_sr[BYTE_W-2:0], miso};
            end
            if (load) begin
                tx_sr   <= load_byte;
                bit_cnt <= '0;
            end else if (fall) begin
                tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + BC_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_len_txhold.sv
module spi_len_txhold
    import spi_len_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  word_t wr_data,
    input  logic  take,
    input  lane_t sel,
    output logic  avail,
    output byte_t sel_byte,
    output logic  hold_empty
);
    word_t hold_q;
    logic  hold_v;
    word_t shw_q;
    logic  shw_v;
    byte_t lanes [WORD_BYTES];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lanes[g] = shw_q[g*BYTE_W +: BYTE_W];
    end

    assign sel_byte   = lanes[sel];
    assign avail      = shw_v;
    assign hold_empty = !hold_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            hold_v <= 1'b0;
            shw_q  <= '0;
            shw_v  <= 1'b0;
        end else begin
            if (take) begin
                shw_v <= 1'b0;
            end
            if (!shw_v && hold_v) begin
                shw_q  <= hold_q;
                shw_v  <= 1'b1;
                hold_v <= 1'b0;
            end
            if (wr) begin
                hold_q <= wr_data;
                hold_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_len_rxpack.sv
module spi_len_rxpack
    import spi_len_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  push,
    input  lane_t idx,
    input  byte_t in_byte,
    input  logic  final_b,
    output word_t rd_data,
    output logic  rxc
);
    word_t acc_q;
    word_t acc_n;

    always_comb begin
        acc_n = put_lane(acc_q, idx, in_byte);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            rd_data <= '0;
            rxc     <= 1'b0;
        end else begin
            rxc <= 1'b0;
            if (clr) begin
                acc_q <= '0;
            end else if (push) begin
                if (idx == lane_t'(WORD_BYTES - 1) || final_b) begin
                    rd_data <= acc_n;
                    rxc     <= 1'b1;
                    acc_q   <= '0;
                end else begin
                    acc_q <= acc_n;
                end
            end
        end
    end
endmodule

// File: rtl/spi_len_host.sv
module spi_len_host
    import spi_len_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_len_en,
    input  logic              start,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              dre,
    output logic [WORD_W-1:0] rd_data,
    output logic              rxc,
    output logic              txc,
    output logic              sck,
    output logic              ss_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int WCNT_W = LEN_W - IDX_W + 1;

    function automatic logic [LEN_W-1:0] eff_len(logic en, logic [LEN_W-1:0] l);
        return en ? l : LEN_W'(WORD_BYTES);
    endfunction

    function automatic logic [WCNT_W-1:0] words_for(logic [LEN_W-1:0] l);
        logic [LEN_W:0] s;
        s = {1'b0, l} + (LEN_W+1)'(WORD_BYTES - 1);
        return WCNT_W'(s >> IDX_W);
    endfunction

    state_e             st;
    logic [LEN_W-1:0]   len_q;
    logic [DIV_W-1:0]   half_q;
    logic [LEN_W-1:0]   done_cnt;
    logic [WCNT_W-1:0]  words_acc;
    logic               tick;
    logic               clk_en;
    logic               avail;
    logic               hold_empty;
    byte_t              ld_byte;
    byte_t              rx_byte;
    logic               bit_last;
    logic               start_ok;
    logic               locked;
    logic               wr_acc;
    logic               rise;
    logic               fall;
    logic               load;
    logic               take;
    logic [LEN_W-1:0]   ld_cnt;
    logic               push;
    logic               last_byte;
    logic               finish;

    // Control decode
    always_comb begin
        start_ok  = start && (st == ST_IDLE) && !(cfg_len_en && cfg_len == '0);
        locked    = words_acc >= words_for((st == ST_IDLE) ? eff_len(cfg_len_en, cfg_len) : len_q);
        wr_acc    = wr_en && hold_empty && !locked;
        clk_en    = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_TRAIL);
        rise      = (st == ST_SHIFT) && tick && !sck;
        fall      = (st == ST_SHIFT) && tick && sck;
        last_byte = (done_cnt == len_q - LEN_W'(1));
        push      = fall && bit_last;
        finish    = (st == ST_TRAIL) && tick;
        ld_cnt    = (st == ST_SHIFT) ? done_cnt + LEN_W'(1) : done_cnt;
        load      = 1'b0;
        unique case (st)
            ST_LEAD:  load = tick && avail;
            ST_WAIT:  load = avail;
            ST_SHIFT: load = push && !last_byte && avail;
            default:  load = 1'b0;
        endcase
        take = load && ((ld_cnt[IDX_W-1:0] == lane_t'(WORD_BYTES - 1)) ||
                        (ld_cnt == len_q - LEN_W'(1)));
    end

    assign dre = hold_empty;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            len_q     <= '0;
            half_q    <= '0;
            done_cnt  <= '0;
            words_acc <= '0;
            sck       <= 1'b0;
            ss_n      <= 1'b1;
            txc       <= 1'b0;
        end else begin
            if (wr_acc) begin
                words_acc <= words_acc + WCNT_W'(1);
            end
            unique case (st)
                ST_IDLE: begin
                    if (start_ok) begin
                        st       <= ST_LEAD;
                        len_q    <= eff_len(cfg_len_en, cfg_len);
                        half_q   <= cfg_half;
                        done_cnt <= '0;
                        ss_n     <= 1'b0;
                        txc      <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        st <= avail ? ST_SHIFT : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (avail) begin
                        st <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (rise) begin
                        sck <= 1'b1;
                    end else if (fall) begin
                        sck <= 1'b0;
                        if (bit_last) begin
                            done_cnt <= done_cnt + LEN_W'(1);
                            if (last_byte) begin
                                st <= ST_TRAIL;
                            end else if (!avail) begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (finish) begin
                        st        <= ST_IDLE;
                        ss_n      <= 1'b1;
                        txc       <= 1'b1;
                        words_acc <= '0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    spi_len_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .half (half_q),
        .tick (tick)
    );

    spi_len_txhold u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_acc),
        .wr_data    (wr_data),
        .take       (take),
        .sel        (ld_cnt[IDX_W-1:0]),
        .avail      (avail),
        .sel_byte   (ld_byte),
        .hold_empty (hold_empty)
    );

    spi_len_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (ld_byte),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .bit_last  (bit_last)
    );

    spi_len_rxpack u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_ok),
        .push    (push),
        .idx     (done_cnt[IDX_W-1:0]),
        .in_byte (rx_byte),
        .final_b (last_byte),
        .rd_data (rd_data),
        .rxc     (rxc)
    );
endmodule

// File: rtl/spi_len_host_chk.sv
module spi_len_host_chk (
    input logic clk,
    input logic rst,
    input logic sck,
    input logic ss_n,
    input logic dre,
    input logic txc,
    input logic rxc,
    input logic wr_acc
);
    // R2: serial clock high only inside the select window
    a_r2_sck_in_frame: assert property (@(posedge clk) disable iff (rst)
        sck |-> !ss_n);

    // R2: serial clock moves only inside the select window
    a_r2_sck_moves_in_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(sck) |-> !ss_n);

    // R6: receive-complete only during a frame
    a_r6_rxc_in_frame: assert property (@(posedge clk) disable iff (rst)
        rxc |-> !ss_n);

    // R6: receive-complete is a single-cycle pulse
    a_r6_rxc_single: assert property (@(posedge clk) disable iff (rst)
        rxc |=> !rxc);

    // R9: transmit-complete rises with select released and holding empty
    a_r9_txc_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(txc) |-> (ss_n && dre));

    // R9: a new frame clears transmit-complete
    a_r9_txc_cleared_on_start: assert property (@(posedge clk) disable iff (rst)
        $fell(ss_n) |-> !txc);

    // R7: a captured write fills the holding register
    a_r7_write_fills: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !dre);
endmodule

bind spi_len_host spi_len_host_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .sck    (sck),
    .ss_n   (ss_n),
    .dre    (dre),
    .txc    (txc),
    .rxc    (rxc),
    .wr_acc (wr_acc)
);

// File: tb/spi_len_host_tb_top.sv
`timescale 1ns/1ps
module spi_len_host_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd1;
    logic [7:0]  cfg_len = 8'd4;
    logic        cfg_len_en = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        dre;
    logic [31:0] rd_data;
    logic        rxc;
    logic        txc;
    logic        sck;
    logic        ss_n;
    logic        mosi;
    logic        miso;

    always #5 clk = ~clk;

    spi_len_host dut_i (
        .clk(clk), .rst(rst), .cfg_half(cfg_half), .cfg_len(cfg_len),
        .cfg_len_en(cfg_len_en), .start(start), .wr_en(wr_en), .wr_data(wr_data),
        .dre(dre), .rd_data(rd_data), .rxc(rxc), .txc(txc), .sck(sck),
        .ss_n(ss_n), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Target model state
    int         seed_cur = 0;
    int         bitc = 0;
    int         rises = 0;
    logic [7:0] cap_sr = '0;
    logic [7:0] cap [256];
    time        t_rise = 0;
    longint     hi_min = 0;
    longint     hi_max = 0;
    logic [31:0] rxw [64];
    int         rxn = 0;
    int         mosi_bad = 0;

    function automatic logic [7:0] tgt_byte(int s, int k);
        return 8'((s * 29 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [31:0] tx_word(int s, int i);
        return {8'(s ^ 8'h3c), 8'(i), 8'(s + i * 3), 8'(8'ha0 ^ i)};
    endfunction

    assign miso = tgt_byte(seed_cur, bitc / 8)[7 - (bitc % 8)];

    always @(posedge sck) begin
        t_rise = $time;
        rises  = rises + 1;
        if (bitc < 2048) begin
            cap_sr = {cap_sr[6:0], mosi};
            if (bitc % 8 == 7) cap[(bitc / 8) % 256] = cap_sr;
        end
    end

    always @(negedge sck) begin
        longint w;
        w = ($time - t_rise) / 10;
        if (hi_min == 0 || w < hi_min) hi_min = w;
        if (w > hi_max) hi_max = w;
        bitc = bitc + 1;
    end

    // R3: mosi must not change while sck is high
    always @(mosi) begin
        if (!rst && sck) mosi_bad = mosi_bad + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk);
        while (!dre) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic raw_wr(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // mode: 0 normal, 1 stall before data, 2 config change mid-run,
    //       3 write while holding full, 4 write while locked
    task automatic run(input int len, input bit en, input int half,
                       input int seed, input int mode);
        int n, nw, pre, hexp, bad_k;
        logic [31:0] ew;
        n    = en ? len : 4;
        nw   = (n + 3) / 4;
        hexp = (half == 0) ? 1 : half;
        @(negedge clk);
        cfg_len = 8'(len); cfg_len_en = en; cfg_half = 8'(half);
        seed_cur = seed; bitc = 0; rises = 0; hi_min = 0; hi_max = 0;
        rxn = 0; mosi_bad = 0;
        pre = 0;
        if (mode == 0 || mode == 2 || mode == 4) begin
            wr_word(tx_word(seed, 0));
            pre = 1;
        end
        if (mode == 3) begin
            wr_word(tx_word(seed, 0));
            wr_word(tx_word(seed, 1));
            pre = 2;
            chk(dre == 1'b0, "R7", "dre with holding full", longint'(dre), 0);
            raw_wr(32'hdeadbeef);
        end
        if (mode == 4) begin
            @(negedge clk);
            raw_wr(32'hbadc0de5);
            chk(dre == 1'b1, "R8", "dre after locked write", longint'(dre), 1);
        end
        pulse_start();
        if (mode == 2) begin
            cfg_len = 8'd3; cfg_half = 8'd7; cfg_len_en = 1'b0;
        end
        if (mode == 1) begin
            repeat (40) @(negedge clk);
            chk(ss_n == 1'b0 && rises == 0, "R11", "stall ss_n/rises",
                longint'({ss_n, 8'(rises)}), 0);
        end
        fork
            begin
                for (int i = pre; i < nw; i++) wr_word(tx_word(seed, i));
            end
            begin
                @(negedge clk);
                while (!txc) begin
                    if (rxc && rxn < 64) begin
                        rxw[rxn] = rd_data;
                        rxn++;
                    end
                    @(negedge clk);
                end
            end
        join
        // R3 byte order on mosi
        bad_k = -1;
        for (int k = n - 1; k >= 0; k--) begin
            ew = tx_word(seed, k / 4);
            if (cap[k] != ew[8 * (k % 4) +: 8]) bad_k = k;
        end
        if (bad_k >= 0) begin
            ew = tx_word(seed, bad_k / 4);
            chk(0, "R3", $sformatf("mosi byte %0d len %0d", bad_k, n),
                longint'(cap[bad_k]), longint'(ew[8 * (bad_k % 4) +: 8]));
        end else begin
            chk(1, "R3", "mosi bytes", 0, 0);
        end
        chk(mosi_bad == 0, "R3", "mosi changed while sck high", mosi_bad, 0);
        chk(rises == 8 * n, "R4", $sformatf("sck rises len %0d", n), rises, 8 * n);
        chk(hi_min == hexp && hi_max == hexp, "R2", "sck high width",
            hi_max, hexp);
        chk(rxn == nw, "R6", "rxc count", rxn, nw);
        for (int j = 0; j < nw && j < rxn; j++) begin
            ew = '0;
            for (int b = 0; b < 4; b++)
                if (4 * j + b < n) ew[8 * b +: 8] = tgt_byte(seed, 4 * j + b);
            chk(rxw[j] == ew, "R6", $sformatf("rx word %0d len %0d", j, n),
                longint'(rxw[j]), longint'(ew));
        end
        chk(txc == 1'b1 && ss_n == 1'b1 && dre == 1'b1, "R9", "txc/ss_n/dre at end",
            longint'({txc, ss_n, dre}), 7);
        if (mode == 2) chk(1, "R10", "captured config run", 0, 0);
    endtask

    localparam int NVEC = 8;
    // {len, half, seed}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd1,   8'd5, 8'd11},
        {8'd3,   8'd3, 8'd22},
        {8'd4,   8'd2, 8'd33},
        {8'd5,   8'd1, 8'd44},
        {8'd8,   8'd2, 8'd55},
        {8'd255, 8'd1, 8'd66},
        {8'd12,  8'd4, 8'd77},
        {8'd7,   8'd0, 8'd88}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ss_n == 1 && sck == 0 && mosi == 0 && dre == 1 && txc == 0 && rxc == 0,
            "R1", "control outputs after reset",
            longint'({ss_n, sck, mosi, dre, txc, rxc}), longint'(6'b100100));
        chk(rd_data == 32'h0, "R1", "rd_data after reset", longint'(rd_data), 0);

        for (int v = 0; v < NVEC; v++) begin
            run(int'(VEC[v][23:16]), 1'b1, int'(VEC[v][15:8]), int'(VEC[v][7:0]), 0);
        end

        // R4: length disabled gives 4 bytes
        run(9, 1'b0, 2, 99, 0);

        // R5: zero length with enable ignored
        @(negedge clk);
        cfg_len = 8'd0; cfg_len_en = 1'b1; cfg_half = 8'd1; rises = 0;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(ss_n == 1'b1 && txc == 1'b1 && rises == 0, "R5", "zero length start",
            longint'({ss_n, txc, 8'(rises)}), longint'({1'b1, 1'b1, 8'd0}));

        // R8: write after length satisfied is refused, then next run shows it unsent
        run(4, 1'b1, 1, 101, 4);
        run(4, 1'b1, 2, 102, 0);

        // R7: write with holding full discarded
        run(12, 1'b1, 1, 103, 3);

        // R11: stall when no word is ready
        run(8, 1'b1, 2, 104, 1);

        // R10: config change mid-run
        run(10, 1'b1, 2, 105, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule